// File: doc/BRIEF.md
# Pad Function and GPIO Control Registers

This block is a memory-mapped bank of control registers for a row of 96 pads. For each pad it holds a 2-bit function select, a drive-strength code, a pull-up enable, an output data bit and an output enable. It also samples the pad levels through a two-flop synchroniser into a read-only input register. Software reaches it over a plain 32-bit register bus made of an address, a write strobe, write data and combinational read data.

Every writable register has four addresses. One overwrites the whole register, and the other three set, clear or invert only the bits given in the write mask. Software can therefore change one pad without a read-modify-write. A pad drives its output data and output enable onto the pad only while its function select holds the GPIO code. Pads marked reserved by a parameter keep every field at zero and ignore all writes.

Top module: `padmux_regs`

## Requirements
- R1: While reset is asserted and after it is released, every function select, drive code, pull enable, output data and output enable reads as 0. All pad-side outputs are 0.
- R2: The address is decoded as follows. Bits [11:8] select the kind: 0 function, 1 drive, 2 pull, 3 output data, 4 output enable, 5 input. Bits [7:4] give the register index. Bits [3:2] give the access type: 0 overwrite, 1 set, 2 clear, 3 toggle. A read of any of the four access types returns the plain register value.
- R3: The function select of pad p sits at bits [2*(p%16)+1 : 2*(p%16)] of function register p/16. The `pad_func` output carries the same 2-bit field for each pad.
- R4: A write to the set, clear or toggle address ORs, clears or XORs the mask into the register. Bits outside the mask keep their values.
- R5: Each drive register holds 8 pads. Each pad has a 4-bit slot whose low 2 bits at [4*(p%8)+1 : 4*(p%8)] hold the code, where 0 is the weakest, 1 the middle and 2 the strongest. The upper two bits of each slot read 0 and ignore writes. `pad_drv` carries the 2-bit code per pad.
- R6: The pull, output data, output enable and input kinds use bit p%32 of register p/32. `pad_pull` follows the pull bit directly.
- R7: `pad_out` and `pad_oe` of a pad equal its output data and output enable bits only while its function select is 3. Otherwise both are 0.
- R8: An input register reads the pad levels whatever the output enables hold, two clock edges after the pad changes. Writes to input addresses have no effect.
- R9: Reserved pads (parameter `RSVD`, default pads 17, 63 and 73 to 95) read 0 in every kind, including input. They ignore writes and drive 0 on all pad outputs.
- R10: An address whose kind is 6 to 15, whose index is past the last register of its kind, or whose bits [1:0] are nonzero reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 12 | Register byte address |
| reg_we | input | 1 | Write strobe, applied at the clock edge |
| reg_wdata | input | 32 | Write data or bit mask |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pad_in | input | NPADS | Raw pad levels |
| pad_out | output | NPADS | Gated output data per pad |
| pad_oe | output | NPADS | Gated output enable per pad |
| pad_pull | output | NPADS | Pull-up enable per pad |
| pad_func | output | 2*NPADS | Function select per pad |
| pad_drv | output | 2*NPADS | Drive-strength code per pad |

## Verification
A write that changes a pad's function select or output data can land in the same cycle as a change of that pad's input level. The input path must then carry the new level through its two synchroniser stages while the output gating flips on the edge itself. The bench provokes this by changing `pad_in` on every pad in nearly every random cycle, alongside writes of random access types to random kinds, including reserved and unmapped addresses. A behavioural model then judges the result on every falling edge. It keeps a two-entry history of pad levels and per-pad field arrays and compares the read data and all pad outputs.

// File: rtl/padmux_regs.sv
module padmux_regs #(
  parameter int NPADS = 96,
  parameter logic [NPADS-1:0] RSVD = 96'hFFFFFE00_80000000_00020000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [11:0]          reg_addr,
  input  logic                 reg_we,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [NPADS-1:0]     pad_in,
  output logic [NPADS-1:0]     pad_out,
  output logic [NPADS-1:0]     pad_oe,
  output logic [NPADS-1:0]     pad_pull,
  output logic [2*NPADS-1:0]   pad_func,
  output logic [2*NPADS-1:0]   pad_drv
);
  localparam int NFUNC = NPADS / 16;
  localparam int NDRV  = NPADS / 8;
  localparam int NBIT  = NPADS / 32;

  function automatic logic [2*NPADS-1:0] func_mask();
    logic [2*NPADS-1:0] m;
    for (int p = 0; p < NPADS; p++) m[2*p +: 2] = {2{~RSVD[p]}};
    return m;
  endfunction

  function automatic logic [4*NPADS-1:0] drv_mask();
    logic [4*NPADS-1:0] m;
    for (int p = 0; p < NPADS; p++) m[4*p +: 4] = {2'b00, {2{~RSVD[p]}}};
    return m;
  endfunction

  localparam logic [2*NPADS-1:0] FMASK = func_mask();
  localparam logic [4*NPADS-1:0] DMASK = drv_mask();

  function automatic logic [31:0] alter(input logic [31:0] old, input logic [31:0] wd,
                                        input logic [1:0] op);
    case (op)
      2'd0:    return wd;
      2'd1:    return old | wd;
      2'd2:    return old & ~wd;
      default: return old ^ wd;
    endcase
  endfunction

  logic [3:0] kind, idx;
  logic [1:0] op;
  logic       aligned;
  assign kind    = reg_addr[11:8];
  assign idx     = reg_addr[7:4];
  assign op      = reg_addr[3:2];
  assign aligned = (reg_addr[1:0] == 2'b00);

  logic [2*NPADS-1:0] func_q, func_d;
  logic [4*NPADS-1:0] drv_q, drv_d;
  logic [NPADS-1:0]   pull_q, pull_d, dout_q, dout_d, oe_q, oe_d;
  logic [NPADS-1:0]   sync1_q, sync2_q;
  logic [31:0]        cur, nxt;
  logic               hit;

  always_comb begin
    cur = '0;
    hit = 1'b0;
    if (aligned) begin
      case (kind)
        4'd0: if (int'(idx) < NFUNC) begin hit = 1'b1; cur = func_q[idx*32 +: 32]; end
        4'd1: if (int'(idx) < NDRV)  begin hit = 1'b1; cur = drv_q[idx*32 +: 32];  end
        4'd2: if (int'(idx) < NBIT)  begin hit = 1'b1; cur = pull_q[idx*32 +: 32]; end
        4'd3: if (int'(idx) < NBIT)  begin hit = 1'b1; cur = dout_q[idx*32 +: 32]; end
        4'd4: if (int'(idx) < NBIT)  begin hit = 1'b1; cur = oe_q[idx*32 +: 32];   end
        4'd5: if (int'(idx) < NBIT)  cur = sync2_q[idx*32 +: 32] & ~RSVD[idx*32 +: 32];
        default: ;
      endcase
    end
  end

  assign reg_rdata = cur;
  assign nxt = alter(cur, reg_wdata, op);

  always_comb begin
    func_d = func_q;
    drv_d  = drv_q;
    pull_d = pull_q;
    dout_d = dout_q;
    oe_d   = oe_q;
    if (reg_we && hit) begin
      case (kind)
        4'd0:    func_d[idx*32 +: 32] = nxt & FMASK[idx*32 +: 32];
        4'd1:    drv_d[idx*32 +: 32]  = nxt & DMASK[idx*32 +: 32];
        4'd2:    pull_d[idx*32 +: 32] = nxt & ~RSVD[idx*32 +: 32];
        4'd3:    dout_d[idx*32 +: 32] = nxt & ~RSVD[idx*32 +: 32];
        4'd4:    oe_d[idx*32 +: 32]   = nxt & ~RSVD[idx*32 +: 32];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_q  <= '0;
      drv_q   <= '0;
      pull_q  <= '0;
      dout_q  <= '0;
      oe_q    <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      func_q  <= func_d;
      drv_q   <= drv_d;
      pull_q  <= pull_d;
      dout_q  <= dout_d;
      oe_q    <= oe_d;
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  for (genvar p = 0; p < NPADS; p++) begin : g_pad
    logic gpio;
    assign gpio = (func_q[2*p +: 2] == 2'b11);
    assign pad_out[p]      = gpio & dout_q[p];
    assign pad_oe[p]       = gpio & oe_q[p];
    assign pad_drv[2*p +: 2] = drv_q[4*p +: 2];
  end

  assign pad_pull = pull_q;
  assign pad_func = func_q;
endmodule

// File: rtl/padmux_regs_chk.sv
module padmux_regs_chk #(
  parameter int NPADS = 96,
  parameter logic [NPADS-1:0] RSVD = 96'hFFFFFE00_80000000_00020000
) (
  input logic               clk,
  input logic               rst_n,
  input logic [11:0]        reg_addr,
  input logic               reg_we,
  input logic [31:0]        reg_rdata,
  input logic [NPADS-1:0]   pad_in,
  input logic [NPADS-1:0]   pad_out,
  input logic [NPADS-1:0]   pad_oe,
  input logic [NPADS-1:0]   pad_pull,
  input logic [2*NPADS-1:0] pad_func,
  input logic [2*NPADS-1:0] pad_drv
);
  logic [NPADS-1:0] gm;
  logic [1:0]       since_rst;

  for (genvar p = 0; p < NPADS; p++) begin : g_gm
    assign gm[p] = &pad_func[2*p +: 2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (pad_func == '0 && pad_drv == '0 && pad_pull == '0 && pad_out == '0 && pad_oe == '0));

  assert_gating_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out | pad_oe) & ~gm) == '0);

  assert_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pull | pad_out | pad_oe) & RSVD) == '0);

  assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr[11:8] >= 4'd6) |=>
      ($stable(pad_func) && $stable(pad_drv) && $stable(pad_pull) && $stable(pad_out) && $stable(pad_oe)));

  assert_input_ro_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr[11:8] == 4'd5) |=>
      ($stable(pad_func) && $stable(pad_drv) && $stable(pad_pull) && $stable(pad_out) && $stable(pad_oe)));

  for (genvar r = 0; r < NPADS / 32; r++) begin : g_sync
    assert_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd2 && reg_addr == 12'h500 + 12'(r * 16)) |->
        reg_rdata == ($past(pad_in[32*r +: 32], 2) & ~RSVD[32*r +: 32]));
  end
endmodule

bind padmux_regs padmux_regs_chk #(.NPADS(NPADS), .RSVD(RSVD)) u_chk (.*);

// File: tb/padmux_regs_bench.sv
module padmux_regs_bench;
  localparam int N = 96;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst_n = 1'b0;
  logic [11:0]    reg_addr = '0;
  logic           reg_we = 1'b0;
  logic [31:0]    reg_wdata = '0;
  logic [31:0]    reg_rdata;
  logic [N-1:0]   pad_in = '0;
  logic [N-1:0]   pad_out, pad_oe, pad_pull;
  logic [2*N-1:0] pad_func, pad_drv;

  padmux_regs u_padmux_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull(pad_pull),
    .pad_func(pad_func), .pad_drv(pad_drv)
  );

  logic [1:0]   m_func [N];
  logic [1:0]   m_drv  [N];
  logic [N-1:0] m_pull, m_dout, m_oe;
  logic [N-1:0] hist[$];
  string        tag = "R1 reset";
  int           n_cmp = 0;
  int           n_bad = 0;
  bit           done = 0;

  function automatic bit rsv(int p);
    return (p == 17) || (p == 63) || (p >= 73);
  endfunction

  function automatic logic [31:0] mread(logic [11:0] a);
    logic [31:0] r = '0;
    int k = int'(a[11:8]);
    int i = int'(a[7:4]);
    if (a[1:0] != 2'b00) return '0;
    if (k == 0 && i < 6)
      for (int b = 0; b < 16; b++) r[2*b +: 2] = m_func[i*16 + b];
    else if (k == 1 && i < 12)
      for (int b = 0; b < 8; b++) r[4*b +: 2] = m_drv[i*8 + b];
    else if (k >= 2 && k <= 5 && i < 3)
      for (int b = 0; b < 32; b++) begin
        int p = i*32 + b;
        case (k)
          2: r[b] = m_pull[p];
          3: r[b] = m_dout[p];
          4: r[b] = m_oe[p];
          default: r[b] = rsv(p) ? 1'b0 : hist[0][p];
        endcase
      end
    return r;
  endfunction

  task automatic mwrite(logic [11:0] a, logic [31:0] d);
    logic [31:0] o, w;
    int k = int'(a[11:8]);
    int i = int'(a[7:4]);
    if (a[1:0] != 2'b00) return;
    o = mread(a);
    case (a[3:2])
      2'd0: w = d;
      2'd1: w = o | d;
      2'd2: w = o & ~d;
      default: w = o ^ d;
    endcase
    if (k == 0 && i < 6)
      for (int b = 0; b < 16; b++) begin
        if (!rsv(i*16 + b)) m_func[i*16 + b] = w[2*b +: 2];
      end
    else if (k == 1 && i < 12)
      for (int b = 0; b < 8; b++) begin
        if (!rsv(i*8 + b)) m_drv[i*8 + b] = w[4*b +: 2];
      end
    else if (k >= 2 && k <= 4 && i < 3)
      for (int b = 0; b < 32; b++) begin
        int p = i*32 + b;
        if (!rsv(p)) begin
          if (k == 2) m_pull[p] = w[b];
          else if (k == 3) m_dout[p] = w[b];
          else m_oe[p] = w[b];
        end
      end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < N; p++) begin m_func[p] = 2'd0; m_drv[p] = 2'd0; end
      m_pull = '0; m_dout = '0; m_oe = '0;
      hist.delete();
      hist.push_back('0);
      hist.push_back('0);
    end else begin
      if (reg_we) mwrite(reg_addr, reg_wdata);
      hist.push_back(pad_in);
      void'(hist.pop_front());
    end
  end

  task automatic chk(string what, logic [191:0] act, logic [191:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (hist.size() == 2 && !done) begin
      logic [2*N-1:0] ef, ed;
      logic [N-1:0]   eo, ee;
      for (int p = 0; p < N; p++) begin
        ef[2*p +: 2] = m_func[p];
        ed[2*p +: 2] = m_drv[p];
        eo[p] = (m_func[p] == 2'd3) & m_dout[p];
        ee[p] = (m_func[p] == 2'd3) & m_oe[p];
      end
      chk("rdata", 192'(reg_rdata), 192'(mread(reg_addr)));
      chk("pad_func R3", 192'(pad_func), 192'(ef));
      chk("pad_drv R5", 192'(pad_drv), 192'(ed));
      chk("pad_pull R6", 192'(pad_pull), 192'(m_pull));
      chk("pad_out R7", 192'(pad_out), 192'(eo));
      chk("pad_oe R7", 192'(pad_oe), 192'(ee));
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); #1;
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
  endtask

  task automatic rd(logic [11:0] a);
    @(negedge clk); #1;
    reg_addr = a; reg_we = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;

    tag = "R3 select packing";
    wr(12'h000, 32'hFFFF_FFFF);
    wr(12'h010, 32'h0000_000F);
    rd(12'h000); rd(12'h010);

    tag = "R6 single-bit kinds";
    wr(12'h300, 32'hA5A5_A5A5);
    wr(12'h400, 32'hFFFF_FFFF);
    wr(12'h200, 32'h0F0F_0000);
    rd(12'h300); rd(12'h400); rd(12'h200);

    tag = "R4 alias ops";
    wr(12'h304, 32'h0000_00FF);
    wr(12'h308, 32'hF000_000F);
    wr(12'h30C, 32'hFFFF_0000);
    rd(12'h304); rd(12'h308); rd(12'h30C);

    tag = "R5 drive slots";
    wr(12'h100, 32'hFFFF_FFFF);
    wr(12'h114, 32'h2222_2222);
    wr(12'h1B0, 32'h1111_1111);
    rd(12'h100); rd(12'h110); rd(12'h1B0);

    tag = "R7 gpio gating";
    wr(12'h008, 32'h0000_0003);
    wr(12'h004, 32'h0000_0001);
    rd(12'h000);

    tag = "R8 input path";
    @(negedge clk); #1 pad_in = {32'h1234_5678, 32'hFFFF_FFFF, 32'hDEAD_BEEF};
    rd(12'h500); rd(12'h500); rd(12'h510); rd(12'h520);
    wr(12'h500, 32'h0);
    pad_in = '0;
    rd(12'h500); rd(12'h500);

    tag = "R9 reserved pins";
    wr(12'h220, 32'hFFFF_FFFF);
    wr(12'h410, 32'hFFFF_FFFF);
    wr(12'h014, 32'h0000_000C);
    wr(12'h050, 32'hFFFF_FFFF);
    rd(12'h220); rd(12'h410); rd(12'h050);

    tag = "R10 unmapped";
    wr(12'h600, 32'hFFFF_FFFF);
    wr(12'h060, 32'hFFFF_FFFF);
    wr(12'h302, 32'hFFFF_FFFF);
    wr(12'h230, 32'hFFFF_FFFF);
    rd(12'h700); rd(12'h0C0); rd(12'h301);

    tag = "R2 random mix";
    for (int n = 0; n < 4000; n++) begin
      logic [11:0] a;
      a[11:8] = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(6, 15)) : 4'($urandom_range(0, 5));
      a[7:4]  = 4'($urandom_range(0, 12));
      a[3:2]  = 2'($urandom_range(0, 3));
      a[1:0]  = ($urandom_range(0, 15) == 0) ? 2'b10 : 2'b00;
      @(negedge clk); #1;
      reg_addr  = a;
      reg_we    = 1'($urandom_range(0, 1));
      reg_wdata = $urandom;
      if ($urandom_range(0, 3) != 0) pad_in = {$urandom, $urandom, $urandom};
    end

    tag = "R1 reset again";
    @(negedge clk); #1 rst_n = 1'b0; reg_we = 1'b0; reg_addr = 12'h000;
    rd(12'h300); rd(12'h100);
    #1 rst_n = 1'b1;
    rd(12'h400); rd(12'h000);
    @(negedge clk);
    finish_run();
  end
endmodule